// File: doc/BRIEF.md
# Split-Ring Descriptor Chain Fetcher

This block serves one queue of a split-ring paravirtual device. A driver publishes the queue as a single page number and a ring size. From those two values the block derives three base addresses: the descriptor table, the ring of available entries, and the used ring. The used ring starts on the next page boundary after the available ring ends.

When the device side asks for work, the block first reads the index the driver has published and compares it with its own next-available counter. If the queue holds an entry, the block pops the head index and follows the linked chain of descriptors through a simple read port that has a request and a valid response. Each descriptor goes out as one segment carrying its buffer address, its length, and a direction bit. The bit marks a buffer the device writes into (an in segment) or one the device reads from (an out segment). When the chain ends, the block reports the head index, the number of in and out segments, and whether the fetch succeeded, found the queue empty, or stopped on a chain that loops.

The ring size must be a power of two, so that every "modulo ring size" operation is a bit mask.

Top module: `split_ring_fetcher`

## Requirements
- R1: On `cfg_load` while idle, `desc_base` becomes `cfg_pfn` shifted left by 12. `avail_base` becomes `desc_base + 16*cfg_size`. A page number of zero gives all three bases as zero. `cfg_load` is ignored while busy.
- R2: `used_base` is `avail_base + 4 + 2*cfg_size` rounded up to the next multiple of 4096.
- R3: After reset, all three bases and `next_avail` are zero, `busy`, `mem_req`, `done` and `seg_valid` are low, and the counts are zero.
- R4: An accepted `cfg_load` clears `next_avail` to zero.
- R5: A get first reads the 16-bit driver index at `avail_base + 2`. If that index equals `next_avail`, the queue is empty: `done` pulses with `fetch_ok=0` and `loop_err=0`, no other memory read is made, no segment is emitted, and `next_avail` is unchanged.
- R6: On a non-empty queue, the head entry is read at `avail_base + 4 + 2*(next_avail mod size)`. `head_idx` reports that entry mod size, and `next_avail` increments by one, wrapping at 16 bits.
- R7: Descriptor i lies at `desc_base + 16*i` and is fetched as two 8-byte reads. Bytes 0–7 hold the buffer address, bytes 8–11 the length, bytes 12–13 the flags and bytes 14–15 the next index, all little-endian. Each descriptor produces one `seg_valid` pulse carrying its address and length, in chain order.
- R8: A descriptor whose flag bit 1 (value 2) is set is an in segment: `seg_write=1` and it adds to `in_cnt`. Otherwise `seg_write=0` and it adds to `out_cnt`.
- R9: When flag bit 0 (value 1) is set, the walk continues at the next index mod size. When it is clear, `done` pulses with `fetch_ok=1`.
- R10: If the descriptor that brings the walk to ring-size descriptors still has bit 0 set, the walk stops. `done` pulses with `loop_err=1` and `fetch_ok=0`, after exactly ring-size segments.
- R11: The read port has at most one request outstanding. `mem_req` is a one-cycle pulse, and `mem_valid` returns the 8 bytes from `mem_addr` upward, little-endian. A `get_req` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load page number and ring size (taken only while idle) |
| cfg_pfn | input | PFN_W | Queue page number |
| cfg_size | input | IDX_W | Ring size, power of two |
| desc_base | output | ADDR_W | Descriptor table base |
| avail_base | output | ADDR_W | Available ring base |
| used_base | output | ADDR_W | Used ring base, page aligned |
| get_req | input | 1 | Pop and walk the next available chain |
| busy | output | 1 | A get is in progress |
| done | output | 1 | One-cycle pulse at the end of a get |
| fetch_ok | output | 1 | Last get returned a complete chain |
| loop_err | output | 1 | Last get stopped on a looping chain |
| head_idx | output | IDX_W | Head descriptor index of the last chain |
| in_cnt | output | IDX_W | Device-writable segments in the last chain |
| out_cnt | output | IDX_W | Device-readable segments in the last chain |
| next_avail | output | IDX_W | Next available-ring index to consume |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Eight little-endian bytes from mem_addr |
| seg_valid | output | 1 | Segment output pulse |
| seg_write | output | 1 | Segment is device-writable |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment length |

## Verification
Gets are run against several ring contents:
- **Empty queue.** Shows the single index read and that nothing else happens.
- **One-descriptor chain.** Checks the head pop on its own.
- **Mixed three-link chain.** Its head entry and next fields lie beyond the ring size, so it separates masked indexing from raw indexing and in segments from out segments.
- **Self-linked descriptor.** Must trip the loop guard.
- **Full-ring chain that ends cleanly.** Must not trip the guard, which pins the limit to exactly ring size.

A run of five gets on a four-entry ring shows the available-index wrap. A second `get_req` issued during a fetch shows it is dropped. Read latency varies from one to three cycles throughout.

// File: rtl/split_ring_fetcher.sv
module split_ring_fetcher #(
  parameter int ADDR_W    = 64,
  parameter int PFN_W     = 32,
  parameter int IDX_W     = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [PFN_W-1:0]  cfg_pfn,
  input  logic [IDX_W-1:0]  cfg_size,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] avail_base,
  output logic [ADDR_W-1:0] used_base,
  input  logic              get_req,
  output logic              busy,
  output logic              done,
  output logic              fetch_ok,
  output logic              loop_err,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  in_cnt,
  output logic [IDX_W-1:0]  out_cnt,
  output logic [IDX_W-1:0]  next_avail,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [63:0]       mem_rdata,
  output logic              seg_valid,
  output logic              seg_write,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len
);
  localparam logic [ADDR_W-1:0] PG_MASK = (ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_AIDX, S_HEAD, S_DLO, S_DHI} st_t;

  st_t              st;
  logic             pend;
  logic [IDX_W-1:0] qsize, cur;
  logic [IDX_W:0]   walked;
  logic [63:0]      lo_word;

  wire [IDX_W-1:0]  mask    = qsize - 1'b1;
  wire [ADDR_W-1:0] desc_n  = ADDR_W'(cfg_pfn) << PAGE_BITS;
  wire [ADDR_W-1:0] avail_n = desc_n + (ADDR_W'(cfg_size) << 4);
  wire [ADDR_W-1:0] used_n  = (avail_n + ADDR_W'(4) + (ADDR_W'(cfg_size) << 1) + PG_MASK) & ~PG_MASK;
  wire [ADDR_W-1:0] desc_at = desc_base + (ADDR_W'(cur) << 4);

  wire [15:0]       d_flags = mem_rdata[47:32];
  wire [15:0]       d_next  = mem_rdata[63:48];
  wire [IDX_W:0]    walked1 = walked + 1'b1;

  assign busy    = (st != S_IDLE);
  assign mem_req = busy && !pend;

  always_comb begin
    case (st)
      S_AIDX:  mem_addr = avail_base + ADDR_W'(2);
      S_HEAD:  mem_addr = avail_base + ADDR_W'(4) + (ADDR_W'(next_avail & mask) << 1);
      S_DLO:   mem_addr = desc_at;
      S_DHI:   mem_addr = desc_at + ADDR_W'(8);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  pend <= 1'b0;
      desc_base <= '0;  avail_base <= '0;  used_base <= '0;
      qsize <= '0;  cur <= '0;  walked <= '0;  lo_word <= '0;
      next_avail <= '0;  head_idx <= '0;  in_cnt <= '0;  out_cnt <= '0;
      done <= 1'b0;  fetch_ok <= 1'b0;  loop_err <= 1'b0;
      seg_valid <= 1'b0;  seg_write <= 1'b0;  seg_addr <= '0;  seg_len <= '0;
    end else begin
      done      <= 1'b0;
      seg_valid <= 1'b0;
      if (st == S_IDLE) begin
        if (cfg_load) begin
          qsize <= cfg_size;
          next_avail <= '0;
          if (cfg_pfn == '0) begin
            desc_base <= '0;  avail_base <= '0;  used_base <= '0;
          end else begin
            desc_base <= desc_n;  avail_base <= avail_n;  used_base <= used_n;
          end
        end else if (get_req) begin
          st <= S_AIDX;
          fetch_ok <= 1'b0;
          loop_err <= 1'b0;
        end
      end else if (!pend) begin
        pend <= 1'b1;
      end else if (mem_valid) begin
        pend <= 1'b0;
        case (st)
          S_AIDX: begin
            if (mem_rdata[IDX_W-1:0] == next_avail) begin
              st <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_HEAD;
            end
          end
          S_HEAD: begin
            head_idx   <= mem_rdata[IDX_W-1:0] & mask;
            cur        <= mem_rdata[IDX_W-1:0] & mask;
            next_avail <= next_avail + 1'b1;
            walked     <= '0;
            in_cnt     <= '0;
            out_cnt    <= '0;
            st         <= S_DLO;
          end
          S_DLO: begin
            lo_word <= mem_rdata;
            st      <= S_DHI;
          end
          default: begin
            seg_valid <= 1'b1;
            seg_addr  <= lo_word;
            seg_len   <= mem_rdata[31:0];
            seg_write <= d_flags[1];
            if (d_flags[1]) in_cnt <= in_cnt + 1'b1;
            else            out_cnt <= out_cnt + 1'b1;
            walked <= walked1;
            if (!d_flags[0]) begin
              st <= S_IDLE;  done <= 1'b1;  fetch_ok <= 1'b1;
            end else if (walked1 == {1'b0, qsize}) begin
              st <= S_IDLE;  done <= 1'b1;  loop_err <= 1'b1;
            end else begin
              cur <= d_next[IDX_W-1:0] & mask;
              st  <= S_DLO;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             busy,
  input logic             done,
  input logic             fetch_ok,
  input logic             loop_err,
  input logic             mem_req,
  input logic             seg_valid,
  input logic [IDX_W-1:0] in_cnt,
  input logic [IDX_W-1:0] out_cnt,
  input logic [IDX_W-1:0] next_avail
);
  // R11
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R10
  err_not_ok_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && loop_err) |-> !fetch_ok);
  // R7
  seg_window_chk: assert property (@(posedge clk) disable iff (!rst_n) seg_valid |-> (busy || done));
  // R5
  empty_nav_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fetch_ok && !loop_err) |-> $stable(next_avail));
  // R4
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !busy) |=> (next_avail == '0));
  // R8
  counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fetch_ok) |-> (in_cnt != '0 || out_cnt != '0));
endmodule

bind split_ring_fetcher ring_fetch_chk #(.IDX_W(IDX_W)) u_ring_fetch_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .busy(busy), .done(done),
  .fetch_ok(fetch_ok), .loop_err(loop_err), .mem_req(mem_req), .seg_valid(seg_valid),
  .in_cnt(in_cnt), .out_cnt(out_cnt), .next_avail(next_avail)
);

// File: tb/test_split_ring_fetcher.sv
module test_split_ring_fetcher;
  logic        clk = 0, rst_n = 0;
  logic        cfg_load = 0, get_req = 0, mem_valid = 0;
  logic [31:0] cfg_pfn = 0;
  logic [15:0] cfg_size = 0;
  logic [63:0] mem_rdata = 0;
  logic [63:0] desc_base, avail_base, used_base, mem_addr, seg_addr;
  logic        busy, done, fetch_ok, loop_err, mem_req, seg_valid, seg_write;
  logic [15:0] head_idx, in_cnt, out_cnt, next_avail;
  logic [31:0] seg_len;

  split_ring_fetcher i_split_ring_fetcher (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_pfn(cfg_pfn), .cfg_size(cfg_size),
    .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base),
    .get_req(get_req), .busy(busy), .done(done), .fetch_ok(fetch_ok), .loop_err(loop_err),
    .head_idx(head_idx), .in_cnt(in_cnt), .out_cnt(out_cnt), .next_avail(next_avail),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .seg_valid(seg_valid), .seg_write(seg_write), .seg_addr(seg_addr), .seg_len(seg_len));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, nreads = 0;
  byte unsigned mem [0:16383];
  logic [63:0] m_desc = 0, m_avail = 0, m_used = 0;
  logic [15:0] m_size = 0, m_nav = 0;
  logic [63:0] q_addr[$], q_len[$];
  bit          q_wr[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  function automatic logic [63:0] rdn(input logic [63:0] a, input int n);
    logic [63:0] v = 0;
    for (int i = n - 1; i >= 0; i--) v = (v << 8) | 64'(mem[14'(a + 64'(i))]);
    return v;
  endfunction

  task automatic wrn(input logic [63:0] a, input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) mem[14'(a + 64'(i))] = v[8*i +: 8];
  endtask

  task automatic set_desc(input int i, input logic [15:0] fl, input logic [15:0] nx);
    wrn(m_desc + 64'(16*i), 64'hC0DE_0000_0000_0000 | 64'(i << 8) | 64'(m_desc[15:12]), 8);
    wrn(m_desc + 64'(16*i) + 8, 64'(32'h100 + i), 4);
    wrn(m_desc + 64'(16*i) + 12, 64'(fl), 2);
    wrn(m_desc + 64'(16*i) + 14, 64'(nx), 2);
  endtask

  // memory responder: latency 1..3 cycles
  initial begin
    int cnt = 0;
    logic [63:0] cap = 0;
    forever begin
      @(negedge clk);
      mem_valid = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin mem_valid = 1; mem_rdata = rdn(cap, 8); end
      end
      if (mem_req) begin cap = mem_addr; cnt = 1 + (nreads % 3); nreads++; end
    end
  end

  // segment and base monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk("R1 desc_base", desc_base, m_desc);
        chk("R1 avail_base", avail_base, m_avail);
        chk("R2 used_base", used_base, m_used);
      end
      if (seg_valid) begin
        if (q_addr.size() == 0) chk("R7 unexpected segment", 1, 0);
        else begin
          chk("R7 seg_addr", seg_addr, q_addr.pop_front());
          chk("R7 seg_len", 64'(seg_len), q_len.pop_front());
          chk("R8 seg_write", 64'(seg_write), 64'(q_wr.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic configure(input logic [31:0] pfn, input logic [15:0] sz);
    logic [63:0] d, a, u;
    @(negedge clk);
    cfg_pfn = pfn; cfg_size = sz; cfg_load = 1;
    d = 64'(pfn) << 12;
    a = d + 64'(sz) * 16;
    u = ((a + 4 + 64'(sz) * 2 + 4095) / 4096) * 4096;
    @(posedge clk);
    if (pfn == 0) begin m_desc = 0; m_avail = 0; m_used = 0; end
    else begin m_desc = d; m_avail = a; m_used = u; end
    m_size = sz; m_nav = 0;
    @(negedge clk);
    cfg_load = 0;
    chk("R4 next_avail cleared", 64'(next_avail), 0);
  endtask

  task automatic do_get(input string tag, input bit extra, input bit exp_ok, input bit exp_err);
    logic [15:0] aidx, head = 0, cur, fl, mask;
    int cnt = 0, nin = 0, nout = 0, rexp, start, wait_c;
    bit e_ok = 0, e_err = 0;
    mask = m_size - 1;
    aidx = 16'(rdn(m_avail + 2, 2));
    if (aidx != m_nav) begin
      head = 16'(rdn(m_avail + 4 + 64'(2 * (m_nav & mask)), 2)) & mask;
      m_nav++;
      cur = head;
      forever begin
        q_addr.push_back(rdn(m_desc + 64'(16 * cur), 8));
        q_len.push_back(rdn(m_desc + 64'(16 * cur) + 8, 4));
        fl = 16'(rdn(m_desc + 64'(16 * cur) + 12, 2));
        q_wr.push_back(fl[1]);
        if (fl[1]) nin++; else nout++;
        cnt++;
        if (!fl[0]) begin e_ok = 1; break; end
        if (cnt == int'(m_size)) begin e_err = 1; break; end
        cur = 16'(rdn(m_desc + 64'(16 * cur) + 14, 2)) & mask;
      end
    end
    rexp = (aidx == m_nav && cnt == 0) ? 1 : 2 + 2 * cnt;
    start = nreads;
    @(negedge clk); get_req = 1;
    @(negedge clk); get_req = 0;
    if (extra) begin
      chk({tag, " R11 busy during get"}, 64'(busy), 1);
      get_req = 1; @(negedge clk); get_req = 0;
    end
    wait_c = 0;
    while (!done && wait_c < 2000) begin @(negedge clk); wait_c++; end
    chk({tag, " R9 done seen"}, 64'(done), 1);
    chk({tag, " R9 fetch_ok"}, 64'(fetch_ok), 64'(e_ok));
    chk({tag, " R10 loop_err"}, 64'(loop_err), 64'(e_err));
    chk({tag, " R5 ok matches plan"}, 64'(e_ok), 64'(exp_ok));
    chk({tag, " R10 err matches plan"}, 64'(e_err), 64'(exp_err));
    chk({tag, " R5 read count"}, 64'(nreads - start), 64'(rexp));
    chk({tag, " R6 next_avail"}, 64'(next_avail), 64'(m_nav));
    chk({tag, " R7 all segments seen"}, 64'(q_addr.size()), 0);
    if (cnt > 0) begin
      chk({tag, " R6 head_idx"}, 64'(head_idx), 64'(head));
      chk({tag, " R8 in_cnt"}, 64'(in_cnt), 64'(nin));
      chk({tag, " R8 out_cnt"}, 64'(out_cnt), 64'(nout));
    end
    if (extra) begin
      repeat (10) @(negedge clk);
      chk({tag, " R11 extra get ignored busy"}, 64'(busy), 0);
      chk({tag, " R11 extra get ignored nav"}, 64'(next_avail), 64'(m_nav));
    end
    q_addr.delete(); q_len.delete(); q_wr.delete();
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 desc_base", desc_base, 0);
    chk("R3 used_base", used_base, 0);
    chk("R3 next_avail", 64'(next_avail), 0);
    chk("R3 busy", 64'(busy), 0);
    chk("R3 mem_req", 64'(mem_req), 0);
    chk("R3 done", 64'(done), 0);
    chk("R3 seg_valid", 64'(seg_valid), 0);
    chk("R3 counts", 64'({in_cnt, out_cnt}), 0);

    configure(1, 8);
    chk("R1 desc 0x1000", desc_base, 64'h1000);
    chk("R1 avail 0x1080", avail_base, 64'h1080);
    chk("R2 used 0x2000", used_base, 64'h2000);

    wrn(m_avail + 2, 0, 2);
    do_get("empty", 0, 0, 0);

    wrn(m_avail + 4, 3, 2); set_desc(3, 0, 0);
    wrn(m_avail + 2, 1, 2);
    do_get("single", 0, 1, 0);

    wrn(m_avail + 6, 13, 2);
    set_desc(5, 1, 9); set_desc(1, 3, 6); set_desc(6, 2, 0);
    wrn(m_avail + 2, 2, 2);
    do_get("chain R6 masked", 0, 1, 0);

    wrn(m_avail + 8, 3, 2);
    wrn(m_avail + 2, 3, 2);
    do_get("busy R11", 1, 1, 0);

    wrn(m_avail + 10, 7, 2); set_desc(7, 1, 7);
    wrn(m_avail + 2, 4, 2);
    do_get("loop R10", 0, 0, 1);

    for (int i = 0; i < 7; i++) set_desc(i, 1, 16'(i + 1));
    set_desc(7, 2, 0);
    wrn(m_avail + 12, 0, 2);
    wrn(m_avail + 2, 5, 2);
    do_get("full ring R10", 0, 1, 0);

    configure(2, 4);
    chk("R1 desc 0x2000", desc_base, 64'h2000);
    chk("R2 used 0x3000", used_base, 64'h3000);
    for (int i = 0; i < 4; i++) begin
      wrn(m_avail + 4 + 64'(2 * i), 64'(3 - i), 2);
      set_desc(i, 16'(i % 2 == 0 ? 2 : 0), 0);
    end
    wrn(m_avail + 2, 5, 2);
    for (int k = 0; k < 5; k++) do_get("wrap R6", 0, 1, 0);
    chk("R6 wrapped head", 64'(head_idx), 3);
    do_get("wrap empty R5", 0, 0, 0);

    configure(0, 8);
    chk("R1 zero pfn", desc_base | avail_base | used_base, 0);

    configure(3, 16);
    chk("R2 used 0x4000", used_base, 64'h4000);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule